// File: doc/BRIEF.md
# Split Translation Cache with Write-XOR-Execute Enforcement

This block holds two small fully associative address translation caches side by side. One answers instruction fetches and the other answers data reads and writes. Each lookup is combinational: in the same cycle as the request the block reports a hit with the physical address, a miss that tells the surrounding logic a table walk and fill are needed, or a permission fault. A fault also captures the offending virtual address in a fault-address register.

Entries come in through one fill port, which picks the target cache. The two caches are kept mutually exclusive for write and execute rights on a page. A fill that makes a page writable in the data cache removes that page from the instruction cache on the same clock edge. Any fill into the instruction cache removes that page from the data cache on the same clock edge. A flush port invalidates a single page in both caches, or clears everything. Each cache picks its victim by using the lowest free slot first and otherwise a round-robin pointer.

The stored state is the entry arrays, one round-robin pointer per cache and the fault-address register. No sequencing state machine exists: every operation completes in the cycle it is presented.

Top module: `wx_split_tlb`

## Requirements
- R1: After reset every entry in both caches is invalid, so every lookup misses, and `fault_va` reads 0.
- R2: A fetch consults only the instruction cache and a data access only the data cache. A page filled into one cache is not a hit on the other port.
- R3: A lookup whose request is high reports exactly one of hit, miss or fault in the same cycle. On a hit the physical address is the stored 20-bit physical page number above the 12 offset bits of the virtual address. With the request low, hit, miss, fault and the address output are all 0.
- R4: A data fill (`fill_exec`=0) with `fill_perm`=1 installs a readable and writable page in the data cache and invalidates any instruction-cache entry for that page on the same edge.
- R5: An instruction fill (`fill_exec`=1) installs the page in the instruction cache and invalidates any data-cache entry for that page on the same edge, whatever `fill_perm` is.
- R6: A data write that hits an entry with `fill_perm`=0 stored, or a fetch that hits such an entry, raises the port's fault instead of a hit. On the next edge `fault_va` holds the faulting virtual address. If both ports fault in one cycle, the data address is taken. A data read never faults.
- R7: A fill for a page already present in the target cache overwrites that entry in place. No second copy is created and the new physical page and permission take effect.
- R8: A fill for a new page uses the lowest-numbered invalid slot. When the cache is full it uses the slot named by a round-robin pointer, which starts at 0 after reset and advances by one on each such eviction.
- R9: A page flush (`flush_page` with `flush_vpn`) invalidates the matching entries in both caches on one edge.
- R10: A global flush (`flush_all`) invalidates every entry in both caches on one edge.
- R11: A fill in the same cycle as a flush is applied after the flush, so the filled entry survives. A lookup in the same cycle as a fill or flush sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_req | input | 1 | Fetch lookup request |
| if_va | input | 32 | Fetch virtual address |
| if_hit | output | 1 | Fetch translation found and executable |
| if_miss | output | 1 | Fetch page absent from the instruction cache |
| if_fault | output | 1 | Fetch hit a non-executable entry |
| if_pa | output | 32 | Fetch physical address, 0 unless hit |
| d_req | input | 1 | Data lookup request |
| d_we | input | 1 | Data access is a write |
| d_va | input | 32 | Data virtual address |
| d_hit | output | 1 | Data translation found and allowed |
| d_miss | output | 1 | Data page absent from the data cache |
| d_fault | output | 1 | Data write hit a read-only entry |
| d_pa | output | 32 | Data physical address, 0 unless hit |
| fill_valid | input | 1 | Install an entry this cycle |
| fill_exec | input | 1 | 1: target instruction cache, 0: target data cache |
| fill_perm | input | 1 | Executable (instruction fill) or writable (data fill) |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| flush_page | input | 1 | Invalidate one page in both caches |
| flush_vpn | input | 20 | Page number for `flush_page` |
| flush_all | input | 1 | Invalidate all entries in both caches |
| fault_va | output | 32 | Last faulting virtual address |

## Verification
Two functions can act on the same cycle and the same page. A fill can meet a page flush or a global flush, and a fill into one cache can meet a lookup on the other cache's port. Directed cycles present a fill and a flush of one page together with a lookup of that page. The random phase draws fills, flushes and lookups from a pool of only twelve pages, so these collisions, and fetch and data faults landing together, happen often. Each cycle is judged against a bench model that applies flushes and cross-invalidation before the install, and that answers lookups from the contents held before the edge.

// File: rtl/wx_tlb_pkg.sv
package wx_tlb_pkg;
    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PPN_W     = 20;
    localparam int PA_W      = PPN_W + PAGE_BITS;

    typedef enum logic {
        TGT_DATA  = 1'b0,
        TGT_INSTR = 1'b1
    } fill_target_e;
endpackage

// File: rtl/wx_tlb_victim.sv
module wx_tlb_victim #(
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ENTRIES-1:0]         vld,
    input  logic                       advance,
    output logic [$clog2(ENTRIES)-1:0] victim
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // lowest-numbered free slot wins
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim = any_free ? free_idx : ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance && !any_free) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/wx_tlb_bank.sv
module wx_tlb_bank #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_perm,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_perm,
    input  logic             kill_en,
    input  logic [VPN_W-1:0] kill_vpn,
    input  logic             flush_en,
    input  logic [VPN_W-1:0] flush_vpn,
    input  logic             flush_all
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] vld_q, perm_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];

    logic [ENTRIES-1:0] lk_match, fill_match, drop;
    logic [IDX_W-1:0]   match_idx, victim, slot;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g]   = vld_q[g] && (vpn_q[g] == lk_vpn);
        assign fill_match[g] = vld_q[g] && (vpn_q[g] == fill_vpn);
        assign drop[g]       = flush_all
                             || (flush_en && vld_q[g] && (vpn_q[g] == flush_vpn))
                             || (kill_en  && vld_q[g] && (vpn_q[g] == kill_vpn));
    end

    always_comb begin
        lk_ppn    = '0;
        lk_perm   = 1'b0;
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_ppn  = lk_ppn | ppn_q[i];
                lk_perm = lk_perm | perm_q[i];
            end
            if (fill_match[i]) begin
                match_idx = IDX_W'(i);
            end
        end
    end

    assign lk_hit = |lk_match;
    assign slot   = (|fill_match) ? match_idx : victim;

    wx_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (vld_q),
        .advance (fill_en && !(|fill_match)),
        .victim  (victim)
    );

    // invalidations land first, the install overrides its own slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            perm_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i] <= '0;
                ppn_q[i] <= '0;
            end
        end else begin
            vld_q <= vld_q & ~drop;
            if (fill_en) begin
                vld_q[slot]  <= 1'b1;
                perm_q[slot] <= fill_perm;
                vpn_q[slot]  <= fill_vpn;
                ppn_q[slot]  <= fill_ppn;
            end
        end
    end
endmodule

// File: rtl/wx_split_tlb.sv
module wx_split_tlb
    import wx_tlb_pkg::*;
#(
    parameter int I_ENTRIES = 8,
    parameter int D_ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             if_req,
    input  logic [VA_W-1:0]  if_va,
    output logic             if_hit,
    output logic             if_miss,
    output logic             if_fault,
    output logic [PA_W-1:0]  if_pa,
    input  logic             d_req,
    input  logic             d_we,
    input  logic [VA_W-1:0]  d_va,
    output logic             d_hit,
    output logic             d_miss,
    output logic             d_fault,
    output logic [PA_W-1:0]  d_pa,
    input  logic             fill_valid,
    input  logic             fill_exec,
    input  logic             fill_perm,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush_page,
    input  logic [VPN_W-1:0] flush_vpn,
    input  logic             flush_all,
    output logic [VA_W-1:0]  fault_va
);
    fill_target_e tgt;
    logic         i_fill, d_fill, i_kill, d_kill;
    logic         i_found, i_perm, d_found, d_perm;
    logic [PPN_W-1:0] i_ppn, d_ppn;
    logic [VA_W-1:0]  fault_va_q;

    assign tgt    = fill_target_e'(fill_exec);
    assign i_fill = fill_valid && (tgt == TGT_INSTR);
    assign d_fill = fill_valid && (tgt == TGT_DATA);
    assign i_kill = d_fill && fill_perm;   // writable data page leaves the fetch side
    assign d_kill = i_fill;                // executable page leaves the data side

    wx_tlb_bank #(.ENTRIES(I_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_itlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (if_va[VA_W-1:PAGE_BITS]),
        .lk_hit    (i_found),
        .lk_ppn    (i_ppn),
        .lk_perm   (i_perm),
        .fill_en   (i_fill),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .fill_perm (fill_perm),
        .kill_en   (i_kill),
        .kill_vpn  (fill_vpn),
        .flush_en  (flush_page),
        .flush_vpn (flush_vpn),
        .flush_all (flush_all)
    );

    wx_tlb_bank #(.ENTRIES(D_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_dtlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (d_va[VA_W-1:PAGE_BITS]),
        .lk_hit    (d_found),
        .lk_ppn    (d_ppn),
        .lk_perm   (d_perm),
        .fill_en   (d_fill),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .fill_perm (fill_perm),
        .kill_en   (d_kill),
        .kill_vpn  (fill_vpn),
        .flush_en  (flush_page),
        .flush_vpn (flush_vpn),
        .flush_all (flush_all)
    );

    always_comb begin
        if_hit   = if_req && i_found && i_perm;
        if_fault = if_req && i_found && !i_perm;
        if_miss  = if_req && !i_found;
        if_pa    = if_hit ? {i_ppn, if_va[PAGE_BITS-1:0]} : '0;

        d_hit    = d_req && d_found && (!d_we || d_perm);
        d_fault  = d_req && d_found && d_we && !d_perm;
        d_miss   = d_req && !d_found;
        d_pa     = d_hit ? {d_ppn, d_va[PAGE_BITS-1:0]} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_va_q <= '0;
        end else if (d_fault) begin
            fault_va_q <= d_va;
        end else if (if_fault) begin
            fault_va_q <= if_va;
        end
    end

    assign fault_va = fault_va_q;
endmodule

// File: rtl/wx_tlb_checker.sv
module wx_tlb_checker
    import wx_tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             if_req,
    input logic [VA_W-1:0]  if_va,
    input logic             if_hit,
    input logic             if_miss,
    input logic             if_fault,
    input logic             d_req,
    input logic             d_we,
    input logic [VA_W-1:0]  d_va,
    input logic             d_hit,
    input logic             d_miss,
    input logic             d_fault,
    input logic             fill_valid,
    input logic             fill_exec,
    input logic             fill_perm,
    input logic [VPN_W-1:0] fill_vpn,
    input logic             flush_page,
    input logic [VPN_W-1:0] flush_vpn,
    input logic             flush_all,
    input logic [VA_W-1:0]  fault_va
);
    a_r3_fetch_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        if_req |-> $countones({if_hit, if_miss, if_fault}) == 1);

    a_r3_data_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        d_req |-> $countones({d_hit, d_miss, d_fault}) == 1);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_req && !d_req) |-> !(if_hit || if_miss || if_fault || d_hit || d_miss || d_fault));

    a_r6_read_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
        d_fault |-> d_we);

    a_r6_data_fault_latch: assert property (@(posedge clk) disable iff (!rst_n)
        d_fault |=> fault_va == $past(d_va));

    a_r6_fetch_fault_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (if_fault && !d_fault) |=> fault_va == $past(if_va));

    a_r4_write_fill_evicts_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_exec && fill_perm)
        |=> !(if_req && (if_va[VA_W-1:PAGE_BITS] == $past(fill_vpn)) && (if_hit || if_fault)));

    a_r5_exec_fill_evicts_data: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_exec)
        |=> !(d_req && (d_va[VA_W-1:PAGE_BITS] == $past(fill_vpn)) && (d_hit || d_fault)));

    a_r9_page_flush_both: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_page && !(fill_valid && fill_vpn == flush_vpn))
        |=> !(if_req && (if_va[VA_W-1:PAGE_BITS] == $past(flush_vpn)) && (if_hit || if_fault))
         && !(d_req && (d_va[VA_W-1:PAGE_BITS] == $past(flush_vpn)) && (d_hit || d_fault)));

    a_r10_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !fill_valid) |=> !(if_hit || if_fault || d_hit || d_fault));
endmodule

bind wx_split_tlb wx_tlb_checker u_wx_tlb_checker (.*);

// File: tb/wx_split_tlb_bench.sv
module wx_split_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_req = 1'b0, d_req = 1'b0, d_we = 1'b0;
    logic [31:0] if_va = '0, d_va = '0;
    logic        if_hit, if_miss, if_fault, d_hit, d_miss, d_fault;
    logic [31:0] if_pa, d_pa, fault_va;
    logic        fill_valid = 1'b0, fill_exec = 1'b0, fill_perm = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0, flush_vpn = '0;
    logic        flush_page = 1'b0, flush_all = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model: cache 0 = fetch side, cache 1 = data side
    bit        m_v   [2][8];
    bit        m_p   [2][8];
    bit [19:0] m_vpn [2][8];
    bit [19:0] m_ppn [2][8];
    int        m_ptr [2];
    bit [31:0] m_fva;

    always #10 clk = ~clk;

    wx_split_tlb u_wx_split_tlb (.*);

    function automatic int find(int c, bit [19:0] v);
        for (int i = 0; i < 8; i++) if (m_v[c][i] && m_vpn[c][i] == v) return i;
        return -1;
    endfunction

    function automatic int first_free(int c);
        for (int i = 0; i < 8; i++) if (!m_v[c][i]) return i;
        return -1;
    endfunction

    task automatic check(string tag, string what, logic [34:0] act, logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_ptr[c] = 0;
            for (int i = 0; i < 8; i++) begin
                m_v[c][i] = 0; m_p[c][i] = 0; m_vpn[c][i] = '0; m_ppn[c][i] = '0;
            end
        end
        m_fva = '0;
    endtask

    // one cycle: drive after the falling edge, compare, then advance the model
    task automatic op(string tag,
                      bit ir, bit [31:0] iva, bit dr, bit dw, bit [31:0] dva,
                      bit fv, bit fx, bit fp, bit [19:0] fvpn, bit [19:0] fppn,
                      bit fpg, bit [19:0] fpvpn, bit fa);
        int ii, di, c, slot;
        bit e_ih, e_im, e_if, e_dh, e_dm, e_df;
        bit [31:0] e_ipa, e_dpa;
        @(negedge clk);
        if_req = ir; if_va = iva; d_req = dr; d_we = dw; d_va = dva;
        fill_valid = fv; fill_exec = fx; fill_perm = fp; fill_vpn = fvpn; fill_ppn = fppn;
        flush_page = fpg; flush_vpn = fpvpn; flush_all = fa;
        #2;
        ii = find(0, iva[31:12]);
        di = find(1, dva[31:12]);
        e_ih = ir && ii >= 0 && m_p[0][ii >= 0 ? ii : 0];
        e_if = ir && ii >= 0 && !m_p[0][ii >= 0 ? ii : 0];
        e_im = ir && ii < 0;
        e_ipa = e_ih ? {m_ppn[0][ii], iva[11:0]} : 32'h0;
        e_dh = dr && di >= 0 && (!dw || m_p[1][di >= 0 ? di : 0]);
        e_df = dr && dw && di >= 0 && !m_p[1][di >= 0 ? di : 0];
        e_dm = dr && di < 0;
        e_dpa = e_dh ? {m_ppn[1][di], dva[11:0]} : 32'h0;
        check(tag, "fetch port", {if_hit, if_miss, if_fault, if_pa}, {e_ih, e_im, e_if, e_ipa});
        check(tag, "data port",  {d_hit, d_miss, d_fault, d_pa},     {e_dh, e_dm, e_df, e_dpa});
        check(tag, "fault_va",   {3'b0, fault_va},                   {3'b0, m_fva});
        if (e_df)      m_fva = dva;
        else if (e_if) m_fva = iva;
        c = fx ? 0 : 1;
        slot = -1;
        if (fv) begin
            slot = find(c, fvpn);
            if (slot < 0) slot = first_free(c);
            if (slot < 0) begin slot = m_ptr[c]; m_ptr[c] = (m_ptr[c] + 1) % 8; end
        end
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 8; i++) begin
                if (fa) m_v[k][i] = 0;
                if (fpg && m_vpn[k][i] == fpvpn) m_v[k][i] = 0;
                if (fv && k != c && (fx || fp) && m_vpn[k][i] == fvpn) m_v[k][i] = 0;
            end
        if (fv) begin
            m_v[c][slot] = 1; m_p[c][slot] = fp; m_vpn[c][slot] = fvpn; m_ppn[c][slot] = fppn;
        end
    endtask

    task automatic fill(string tag, bit fx, bit fp, bit [19:0] vpn, bit [19:0] ppn);
        op(tag, 0, 0, 0, 0, 0, 1, fx, fp, vpn, ppn, 0, 0, 0);
    endtask

    task automatic look(string tag, bit ir, bit [19:0] ivpn, bit dr, bit dw, bit [19:0] dvpn);
        op(tag, ir, {ivpn, 12'h5a4}, dr, dw, {dvpn, 12'h1c8}, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0b1e));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset
        look("R1", 1, 20'h00010, 1, 0, 20'h00010);
        look("R1", 1, 20'h00000, 1, 1, 20'h00000);

        // R2 / R3: data fill is invisible to fetches; hit returns ppn:offset
        fill("R2", 0, 1, 20'h00010, 20'h12345);
        look("R2", 1, 20'h00010, 1, 0, 20'h00010);
        look("R3", 0, 20'h00010, 0, 0, 20'h00010);

        // R5: execute fill moves the page to the fetch side
        fill("R5", 1, 1, 20'h00010, 20'h0abcd);
        look("R5", 1, 20'h00010, 1, 1, 20'h00010);
        // R4: writable data fill moves it back
        fill("R4", 0, 1, 20'h00010, 20'h12345);
        look("R4", 1, 20'h00010, 1, 1, 20'h00010);

        // R6: read-only data page and non-executable code page fault
        fill("R6", 0, 0, 20'h00020, 20'h00777);
        look("R6", 0, 20'h0, 1, 0, 20'h00020);
        look("R6", 0, 20'h0, 1, 1, 20'h00020);
        fill("R6", 1, 0, 20'h00030, 20'h00888);
        look("R6", 1, 20'h00030, 0, 0, 20'h0);
        look("R6", 1, 20'h00030, 1, 1, 20'h00020);
        look("R6", 0, 20'h0, 0, 0, 20'h0);

        // R7: refill in place with a new frame and permission
        fill("R7", 0, 1, 20'h00020, 20'h00999);
        look("R7", 0, 20'h0, 1, 1, 20'h00020);

        // R8: free slots first, then round robin from slot 0
        op("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        look("R10", 1, 20'h00010, 1, 0, 20'h00010);
        for (int k = 0; k < 8; k++) fill("R8", 0, 1, 20'h00100 + 20'(k), 20'h00200 + 20'(k));
        fill("R8", 0, 1, 20'h00108, 20'h00208);
        look("R8", 0, 20'h0, 1, 0, 20'h00100);
        look("R8", 0, 20'h0, 1, 0, 20'h00101);
        fill("R8", 0, 1, 20'h00109, 20'h00209);
        look("R8", 0, 20'h0, 1, 0, 20'h00101);
        look("R8", 0, 20'h0, 1, 0, 20'h00102);

        // R9: page present in both caches (exec, then read-only data) flushed at once
        fill("R9", 1, 1, 20'h00040, 20'h00444);
        fill("R9", 0, 0, 20'h00040, 20'h00555);
        look("R9", 1, 20'h00040, 1, 0, 20'h00040);
        op("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 20'h00040, 0);
        look("R9", 1, 20'h00040, 1, 0, 20'h00040);

        // R11: fill meets flush of the same page, lookup sees old contents
        op("R11", 0, 0, 1, 0, {20'h00050, 12'h0}, 1, 0, 1, 20'h00050, 20'h00666, 1, 20'h00050, 0);
        look("R11", 0, 20'h0, 1, 0, 20'h00050);
        op("R11", 1, {20'h00050, 12'h0}, 1, 0, {20'h00103, 12'h0}, 1, 1, 1, 20'h00050, 20'h00667, 0, 0, 1);
        look("R11", 1, 20'h00050, 1, 0, 20'h00050);
        look("R10", 1, 20'h00103, 1, 0, 20'h00103);

        // random phase over a small page pool
        for (int n = 0; n < 4000; n++) begin
            bit [19:0] pv, pf, pl, pd;
            pv = 20'h00400 + 20'($urandom_range(0, 11));
            pf = 20'h00400 + 20'($urandom_range(0, 11));
            pl = 20'h00400 + 20'($urandom_range(0, 11));
            pd = 20'h00400 + 20'($urandom_range(0, 11));
            op("R3",
               $urandom_range(0, 9) < 8, {pl, 12'($urandom)},
               $urandom_range(0, 9) < 8, 1'($urandom), {pd, 12'($urandom)},
               $urandom_range(0, 9) < 3, 1'($urandom), 1'($urandom), pv, 20'($urandom),
               $urandom_range(0, 19) == 0, pf, $urandom_range(0, 99) == 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule